// File: doc/BRIEF.md
# Dual-Channel Converter Code Register Bank

This block sits between an 8-bit register write bus and two 12-bit digital-to-analog converter channels. Software writes each channel's code as two bytes, a high byte whose lower nibble carries code bits 11:8 and a low byte carrying bits 7:0. These bytes land in pending registers. A separate output latch per channel holds the code that the converter actually sees.

A shared control byte decides when pending codes reach the latches. With the sync control set, writing a channel's low byte moves that channel's pending pair into its latch in the same clock edge. With sync clear, writes only stage codes. A later control write that turns sync from 0 to 1 moves both staged codes together, so both outputs change on one edge. Each channel also has a clear control and a power-down control, and either one forces its output code to zero without losing the latched value. Range and mode bits are kept for software and have no effect here. The bus is a plain register port with no back-pressure: every write is taken in the cycle it is presented, and reads are combinational from the address.

Top module: `dual_dac_regif`

## Requirements
- R1: After synchronous reset every pending and latched code is 0, the control byte reads 0xF4 (sync, both clear bits and both power-down bits set), both output codes are 0 and `pd_stat` is 2'b11.
- R2: The address map is 0 = control, 1 = channel 0 low byte, 2 = channel 0 high byte, 3 = channel 1 low byte, 4 = channel 1 high byte; each register reads back what was written, a high-byte register keeps only bits 3:0 and reads bits 7:4 as 0, and addresses 5 to 7 read 0 and writes to them change nothing.
- R3: While control bit 2 (sync) is 1, a low-byte write loads that channel's latch with {pending high nibble, written low byte}, visible on `dac_code` after that clock edge.
- R4: A high-byte write alone never changes a channel's latch, in either sync state.
- R5: While sync is 0, byte writes change only the pending registers; both output codes hold their previous values.
- R6: A control write that changes sync from 0 to 1 loads both channels' latches from their pending registers on the same edge; a control write while sync is already 1 loads nothing.
- R7: While a channel's clear bit (control bit 4 for channel 0, bit 5 for channel 1) is 1, its output code is 0; its latch is kept and reappears when the bit is cleared.
- R8: While a channel's power-down bit (control bit 6 for channel 0, bit 7 for channel 1) is 1, its output code is 0 and its `pd_stat` bit is 1; register writes and transfers to that channel still take effect.
- R9: Control bit 0 (mode), bit 1 (channel 0 range) and bit 3 (channel 1 range) are stored and read back but do not change any output code.
- R10: A full-scale code 0x0FFF written as one high/low pair with sync set reaches the output in one transfer, from any previous code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dac_code | output | 24 | Converter codes, channel 0 in bits 11:0, channel 1 in bits 23:12 |
| pd_stat | output | 2 | Per-channel power-down status, bit n for channel n |

## Verification
A wrong latch shows at once on `dac_code` in the cycle after the write or control change that should have moved it, unless clear or power-down masks that channel, so the bench releases those masks before checking and again afterwards to expose a latch damaged while hidden. A wrong pending register is invisible at the output until the next transfer, so every staging scenario ends with a transfer and a readback of the pending bytes. A sync edge that moves only one channel, or moves on a redundant control write, shows as one code changing when it should hold, on the next cycle.

// File: rtl/dac_regif_pkg.sv
package dac_regif_pkg;
  localparam int BYTE_W = 8;
  localparam int CODE_W = 12;
  localparam int HI_W   = CODE_W - BYTE_W;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = '0;

  // control bit positions; sync position is fixed by software convention
  localparam int B_MODE = 0;
  localparam int B_SYNC = 2;
  localparam logic [BYTE_W-1:0] CTRL_RST = 8'hF4;

  function automatic int rng_bit(input int ch);
    return (ch == 0) ? 1 : 3;
  endfunction

  function automatic int clr_bit(input int ch);
    return 4 + ch;
  endfunction

  function automatic int pd_bit(input int ch);
    return 6 + ch;
  endfunction

  function automatic logic [ADDR_W-1:0] lo_addr(input int ch);
    return ADDR_W'(1 + 2 * ch);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_addr(input int ch);
    return ADDR_W'(2 + 2 * ch);
  endfunction
endpackage

// File: rtl/dac_ctrl_reg.sv
module dac_ctrl_reg
  import dac_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctrl_o,
  output logic              sync_o,
  output logic              xfer_all_o
);
  logic [BYTE_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RST;
    else if (we) ctrl_q <= wdata;
  end

  assign ctrl_o     = ctrl_q;
  assign sync_o     = ctrl_q[B_SYNC];
  // strobe on the write that turns sync on
  assign xfer_all_o = we & wdata[B_SYNC] & ~ctrl_q[B_SYNC];

  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(ctrl_q));
  assert_sync_edge_only_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_all_o |=> ctrl_q[B_SYNC] && !$past(ctrl_q[B_SYNC]));
endmodule

// File: rtl/dac_channel.sv
module dac_channel
  import dac_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              sync,
  input  logic              xfer_all,
  input  logic              clr,
  input  logic              pd,
  output logic [BYTE_W-1:0] lo_o,
  output logic [HI_W-1:0]   hi_o,
  output logic [CODE_W-1:0] code_o,
  output logic              pd_stat_o
);
  logic [BYTE_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [CODE_W-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      if (lo_we) lo_q <= wdata;
      if (hi_we) hi_q <= wdata[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                latch_q <= '0;
    else if (lo_we && sync) latch_q <= {hi_q, wdata};
    else if (xfer_all)      latch_q <= {hi_q, lo_q};
  end

  assign code_o    = (clr || pd) ? '0 : latch_q;
  assign pd_stat_o = pd;
  assign lo_o      = lo_q;
  assign hi_o      = hi_q;

  assert_hi_only_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (hi_we && !xfer_all) |=> $stable(latch_q));
  assert_staged_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!sync && !xfer_all) |=> $stable(latch_q));
  assert_lo_load_R3: assert property (@(posedge clk) disable iff (rst)
    (lo_we && sync) |=> latch_q == {$past(hi_q), $past(wdata)});
  assert_joint_load_R6: assert property (@(posedge clk) disable iff (rst)
    xfer_all |=> latch_q == {$past(hi_q), $past(lo_q)});
  assert_mask_keeps_latch_R7: assert property (@(posedge clk) disable iff (rst)
    ((clr || pd) && !lo_we && !xfer_all) |=> $stable(latch_q));
endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
  import dac_regif_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        pd_stat
);
  logic [BYTE_W-1:0] ctrl;
  logic              sync, xfer_all;
  logic              ctrl_we;
  logic [BYTE_W-1:0] lo_rb [NCH];
  logic [BYTE_W-1:0] hi_rb [NCH];

  assign ctrl_we = bus_we && (bus_addr == A_CTRL);

  dac_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .we         (ctrl_we),
    .wdata      (bus_wdata),
    .ctrl_o     (ctrl),
    .sync_o     (sync),
    .xfer_all_o (xfer_all)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [HI_W-1:0] hi_v;

    dac_channel u_ch (
      .clk       (clk),
      .rst       (rst),
      .lo_we     (bus_we && (bus_addr == lo_addr(c))),
      .hi_we     (bus_we && (bus_addr == hi_addr(c))),
      .wdata     (bus_wdata),
      .sync      (sync),
      .xfer_all  (xfer_all),
      .clr       (ctrl[clr_bit(c)]),
      .pd        (ctrl[pd_bit(c)]),
      .lo_o      (lo_rb[c]),
      .hi_o      (hi_v),
      .code_o    (dac_code[c*CODE_W +: CODE_W]),
      .pd_stat_o (pd_stat[c])
    );

    assign hi_rb[c] = {{(BYTE_W-HI_W){1'b0}}, hi_v};
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctrl;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == lo_addr(c)) bus_rdata = lo_rb[c];
      if (bus_addr == hi_addr(c)) bus_rdata = hi_rb[c];
    end
  end

  assert_pd_status_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_we) |-> pd_stat == {$past(bus_wdata[pd_bit(1)]), $past(bus_wdata[pd_bit(0)])});
  assert_rdata_known_R2: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(bus_rdata));
endmodule

// File: tb/dual_dac_regif_tb.sv
`timescale 1ns/1ps
module dual_dac_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       bus_we;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [23:0] dac_code;
  logic [1:0] pd_stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dual_dac_regif dut_i (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dac_code(dac_code), .pd_stat(pd_stat)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic int c0(); return int'(dac_code[11:0]);  endfunction
  function automatic int c1(); return int'(dac_code[23:12]); endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d); check("R1 ctrl", d, 8'hF4);
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), d); check("R1 code reg", d, 0);
    end
    check("R1 code0", c0(), 0);
    check("R1 code1", c1(), 0);
    check("R1 pd_stat", pd_stat, 2'b11);
  endtask

  task automatic t_readback_and_load();
    logic [7:0] d;
    wr(3'd0, 8'h04);
    check("R8 pd_stat off", pd_stat, 2'b00);
    wr(3'd2, 8'hAB);
    rd(3'd2, d); check("R2 hi nibble only", d, 8'h0B);
    check("R4 hi write no move", c0(), 0);
    wr(3'd1, 8'h5C);
    rd(3'd1, d); check("R2 lo readback", d, 8'h5C);
    check("R3 lo write loads", c0(), 12'hB5C);
    wr(3'd4, 8'h37);
    rd(3'd4, d); check("R2 hi1 readback", d, 8'h07);
    wr(3'd6, 8'hEE);
    rd(3'd6, d); check("R2 unmapped reads 0", d, 0);
    rd(3'd0, d); check("R2 unmapped write ignored", d, 8'h04);
    check("R2 unmapped no code move", c0(), 12'hB5C);
  endtask

  task automatic t_hi_only();
    wr(3'd2, 8'h02);
    check("R4 hi write sync set", c0(), 12'hB5C);
    wr(3'd1, 8'h00);
    check("R3 pair load", c0(), 12'h200);
  endtask

  task automatic t_full_scale();
    wr(3'd2, 8'h00); wr(3'd1, 8'h00);
    check("R10 from zero", c0(), 0);
    wr(3'd2, 8'h0F); wr(3'd1, 8'hFF);
    check("R10 full scale one transfer", c0(), 12'hFFF);
  endtask

  task automatic t_staged_sync();
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h01); wr(3'd1, 8'h23);
    wr(3'd4, 8'h04); wr(3'd3, 8'h56);
    check("R5 ch0 held", c0(), 12'hFFF);
    check("R5 ch1 held", c1(), 0);
    wr(3'd0, 8'h04);
    check("R6 ch0 moved", c0(), 12'h123);
    check("R6 ch1 moved", c1(), 12'h456);
    wr(3'd4, 8'h09);
    wr(3'd0, 8'h04);
    check("R6 no move when sync stays", c1(), 12'h456);
    check("R4 hi write then redundant sync", c0(), 12'h123);
  endtask

  task automatic t_clear();
    wr(3'd0, 8'h14);
    check("R7 ch0 cleared", c0(), 0);
    check("R7 ch1 unaffected", c1(), 12'h456);
    wr(3'd0, 8'h04);
    check("R7 latch reappears", c0(), 12'h123);
  endtask

  task automatic t_powerdown();
    logic [7:0] d;
    wr(3'd0, 8'h84);
    check("R8 ch1 forced 0", c1(), 0);
    check("R8 pd_stat", pd_stat, 2'b10);
    wr(3'd4, 8'h0A); wr(3'd3, 8'hBC);
    rd(3'd3, d); check("R8 write accepted", d, 8'hBC);
    check("R8 still 0", c1(), 0);
    wr(3'd0, 8'h04);
    check("R8 load during pd shows", c1(), 12'hABC);
  endtask

  task automatic t_range_mode();
    logic [7:0] d;
    wr(3'd0, 8'h0F);
    rd(3'd0, d); check("R9 readback", d, 8'h0F);
    check("R9 ch0 unaffected", c0(), 12'h123);
    check("R9 ch1 unaffected", c1(), 12'hABC);
  endtask

  initial begin
    rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_readback_and_load();
    t_hi_only();
    t_full_scale();
    t_staged_sync();
    t_clear();
    t_powerdown();
    t_range_mode();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule